// File: doc/BRIEF.md
# Framed Serial Gray Code Converter

This block converts words that arrive one bit per clock, most significant bit first, between plain binary and reflected Gray code. Each output bit appears in the same cycle as the input bit that produced it. The words have a fixed length of three bits by default, and a parameter sets that length. A single direction input selects the conversion. The block samples that input only on the first valid bit of a word, so the whole word is converted in one direction.

The block keeps a small amount of state: the bit position inside the current word, one history bit, and the direction latched for the word in progress. Bits qualified by `in_valid` advance the position. Cycles with `in_valid` low change nothing, so a word may be spread over any number of idle cycles. On the last bit of a word the block raises a strobe and clears its history, which lets the next word follow directly with no idle cycle between them.

Top module: `gray_serial_conv`

## Requirements
- R1: While `rst` is high at a clock edge, the position returns to the first bit and the history clears, so the next valid bit after reset starts a new word even if the reset came in the middle of a word.
- R2: The first valid bit of every word passes through unchanged: `out_bit` equals `in_bit`.
- R3: When `mode` is 0 (binary to Gray), each later bit of the word is `in_bit` XOR the previous valid input bit of the same word. For 3-bit words this gives 000→000, 011→010, 100→110 and 111→100.
- R4: When `mode` is 1 (Gray to binary), each later bit of the word is `in_bit` XOR the previous output bit of the same word.
- R5: The block samples `mode` only on the first valid bit of a word. Changes to `mode` on later bits or during idle cycles have no effect on that word.
- R6: `out_valid` equals `in_valid` in the same cycle. While `in_valid` is low, `out_bit` and `frame_end` are 0.
- R7: `frame_end` is high exactly on the valid cycle that carries the last bit of a word (the third bit by default), and it is high together with `out_valid`.
- R8: Idle cycles inside a word keep the position, the history and the latched direction, so the word resumes where it stopped.
- R9: A word that follows the last bit of the previous word on the very next cycle is converted as if nothing had come before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial input data, most significant bit first |
| in_valid | input | 1 | High when `in_bit` carries a bit of the current word |
| mode | input | 1 | Direction: 0 binary to Gray, 1 Gray to binary; sampled on a word's first bit |
| out_bit | output | 1 | Converted serial bit, valid in the same cycle as its input bit |
| out_valid | output | 1 | Qualifies `out_bit` |
| frame_end | output | 1 | High on the last bit of each word |

## Verification
Two functions can meet in one cycle: the last bit of one word, with its strobe and the history clear, and the first bit of the next word, whose direction is sampled on that next cycle. Sending words back to back, with the direction flipped between them, makes a missed clear or a stale direction corrupt the second word. Two more cases put a sampling point right next to a change: idle cycles and direction changes in the middle of a word, and a reset in the middle of a word. A bench model computes each expected word from the word value and the sampled direction, and every output bit and strobe is compared against that model.

// File: rtl/gray_serial_pkg.sv
`timescale 1ns/1ps
package gray_serial_pkg;
  typedef enum logic {
    DIR_BIN2GRAY = 1'b0,
    DIR_GRAY2BIN = 1'b1
  } conv_dir_e;
endpackage

// File: rtl/gray_frame_pos.sv
`timescale 1ns/1ps
module gray_frame_pos #(
  parameter int FRAME_BITS = 3,
  localparam int POS_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic             is_first,
  output logic             is_last
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (step)
      pos <= is_last ? '0 : pos + 1'b1;
  end

  always_comb begin
    is_first = (pos == '0);
    is_last  = (pos == LAST_POS);
  end

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));

  // R7
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && is_last) |=> (pos == '0));

  // R1
  pos_reset_chk: assert property (@(posedge clk)
    rst |=> (pos == '0));
endmodule

// File: rtl/gray_hist_bit.sv
`timescale 1ns/1ps
module gray_hist_bit (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic word_done,
  input  logic next_val,
  output logic hist
);
  always_ff @(posedge clk) begin
    if (rst)
      hist <= 1'b0;
    else if (step)
      hist <= word_done ? 1'b0 : next_val;
  end

  // R9
  hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (step && word_done) |=> !hist);

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(hist));
endmodule

// File: rtl/gray_serial_conv.sv
`timescale 1ns/1ps
module gray_serial_conv
  import gray_serial_pkg::*;
#(
  parameter int FRAME_BITS = 3,
  localparam int POS_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  input  logic mode,
  output logic out_bit,
  output logic out_valid,
  output logic frame_end
);
  logic [POS_W-1:0] pos;
  logic             is_first;
  logic             is_last;
  logic             hist;
  logic             raw_bit;
  logic             hist_next;
  conv_dir_e        dir_q;
  conv_dir_e        dir_eff;

  gray_frame_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .step     (in_valid),
    .pos      (pos),
    .is_first (is_first),
    .is_last  (is_last)
  );

  // Direction is taken from the port on a word's first bit, then held.
  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= DIR_BIN2GRAY;
    else if (in_valid && is_first)
      dir_q <= conv_dir_e'(mode);
  end

  always_comb begin
    dir_eff   = is_first ? conv_dir_e'(mode) : dir_q;
    raw_bit   = in_bit ^ hist;
    hist_next = (dir_eff == DIR_BIN2GRAY) ? in_bit : raw_bit;
    out_bit   = in_valid & raw_bit;
    out_valid = in_valid;
    frame_end = in_valid & is_last;
  end

  gray_hist_bit u_hist (
    .clk       (clk),
    .rst       (rst),
    .step      (in_valid),
    .word_done (is_last),
    .next_val  (hist_next),
    .hist      (hist)
  );

  // R2
  msb_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos == '0) |-> (out_bit == in_bit));

  // R5
  dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos != '0) |=> $stable(dir_q));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!out_valid && !out_bit && !frame_end));

  // R7
  end_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> out_valid);
endmodule

// File: tb/gray_serial_conv_bench.sv
`timescale 1ns/1ps
module gray_serial_conv_bench;
  localparam int FB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic mode = 1'b0;
  logic out_bit, out_valid, frame_end;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gray_serial_conv #(.FRAME_BITS(FB)) u_gray_serial_conv (
    .clk       (clk),
    .rst       (rst),
    .in_bit    (in_bit),
    .in_valid  (in_valid),
    .mode      (mode),
    .out_bit   (out_bit),
    .out_valid (out_valid),
    .frame_end (frame_end)
  );

  function automatic logic [FB-1:0] ref_conv(input logic [FB-1:0] w, input logic m);
    logic [FB-1:0] r;
    if (!m) begin
      r = w ^ (w >> 1);
    end else begin
      r[FB-1] = w[FB-1];
      for (int i = FB - 2; i >= 0; i--) r[i] = w[i] ^ r[i+1];
    end
    return r;
  endfunction

  task automatic cmp(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_cycle(input logic m);
    @(negedge clk);
    in_valid = 1'b0;
    in_bit   = $urandom_range(0, 1);
    mode     = m;
    #1;
    cmp("R6 out_valid idle", out_valid, 1'b0);
    cmp("R6 out_bit idle", out_bit, 1'b0);
    cmp("R6 frame_end idle", frame_end, 1'b0);
  endtask

  // Sends one word. gap_max: idle cycles allowed before each bit;
  // scramble: mode port is randomised after the first bit (R5).
  task automatic send_word(input logic [FB-1:0] w, input logic m,
                           input int gap_max, input bit scramble, input string req);
    logic [FB-1:0] exp_w;
    exp_w = ref_conv(w, m);
    for (int k = 0; k < FB; k++) begin
      int gaps;
      gaps = (k == 0 || gap_max == 0) ? 0 : $urandom_range(0, gap_max);
      for (int g = 0; g < gaps; g++) idle_cycle(scramble ? logic'($urandom_range(0, 1)) : m); // R8
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = w[FB-1-k];
      mode     = (k == 0 || !scramble) ? m : logic'($urandom_range(0, 1));
      #1;
      cmp({req, " out_bit"}, out_bit, exp_w[FB-1-k]);
      cmp("R6 out_valid", out_valid, 1'b1);
      cmp("R7 frame_end", frame_end, (k == FB - 1));
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 out_valid in reset", out_valid, 1'b0);
    cmp("R1 frame_end in reset", frame_end, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Every word in both directions, back to back (R2 R3 R4 R9).
    for (int w = 0; w < (1 << FB); w++) send_word(FB'(w), 1'b0, 0, 1'b0, "R3 b2g");
    for (int w = 0; w < (1 << FB); w++) send_word(FB'(w), 1'b1, 0, 1'b0, "R4 g2b");
    // Direction flips between adjacent words (R9 R5).
    for (int w = 0; w < (1 << FB); w++) send_word(FB'(w), logic'(w[0]), 0, 1'b0, "R9 flip");

    // Random words, idle gaps and mid-word mode noise (R5 R8).
    for (int n = 0; n < 300; n++)
      send_word(FB'($urandom_range(0, (1 << FB) - 1)), logic'($urandom_range(0, 1)),
                $urandom_range(0, 3), 1'b1, "R5 R8 random");

    // Reset in the middle of a word (R1).
    @(negedge clk); in_valid = 1'b1; in_bit = 1'b1; mode = 1'b1;
    @(negedge clk); in_bit = 1'b0;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send_word(3'b110, 1'b1, 0, 1'b0, "R1 restart");
    send_word(3'b111, 1'b0, 0, 1'b0, "R1 restart");
    idle_cycle(1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule